// File: doc/BRIEF.md
# Delay-Matched Dedicated Processing Element

This block is one processing element of a statically configured spatial compute array. Once configured it holds a single operation and executes it fully pipelined, taking a fresh operand pair every clock. Both operands are picked from a set of neighbouring switch ports. Each operand then passes through its own programmable delay line, which lets a compiler line up operands that reached the element over routes of unequal length. No handshake exists anywhere on the datapath: data moves with fixed latency, and a valid bit travels alongside each value.

The element has three ways of producing output. In compute mode it emits one result per aligned operand pair. In pass-through mode it acts as a routing hop and forwards operand A one cycle later. In accumulate mode it folds every result into an internal reduction register, and it presents that register only when asked to emit. The operations are 64-bit add, subtract, low-half multiply, AND, OR, XOR, and a lane-wise add of four independent 16-bit lanes.

A small controller holds the configuration and has three states. UNCFG is entered at reset. LOAD is active while the configuration enable is high, and the configuration word is captured on every cycle of LOAD. RUN is the operating state. The transitions are: UNCFG→LOAD and RUN→LOAD when the enable is high; LOAD→RUN when the enable falls; LOAD→LOAD while the enable stays high; UNCFG→UNCFG and RUN→RUN when the enable is low.

Top module: `spatial_pe`

## Requirements
- R1: After reset, out_valid and out_data are 0 and the controller is in UNCFG. No output becomes valid before a configuration has been loaded.
- R2: A high cfg_en moves the controller to LOAD from any state. The first cycle with cfg_en low in LOAD moves it to RUN. In any cycle that is not RUN, the next output is invalid, both delay lines are emptied and the accumulator is cleared.
- R3: The configuration word is captured on each clock edge where cfg_en is high. Its layout with default parameters is: opcode in bits 2:0, select A in bits 4:3, select B in bits 6:5, delay A in bits 9:7, delay B in bits 12:10, pass-through in bit 13, accumulate in bit 14. Outside LOAD the configuration stays unchanged.
- R4: Operand A is taken from port in_data[selA*64 +: 64], qualified by in_valid[selA]. Operand B is taken the same way from selB.
- R5: In RUN, the output after edge t+1 is op(A(t−dA), B(t−dB)). It is valid only when both delayed operands were valid and every cycle from t−max(dA,dB) through t was a RUN cycle. A delay of 0 therefore gives one cycle of latency.
- R6: The opcode encodings are 0 = add, 1 = subtract (A−B), 2 = multiply (low 64 bits), 3 = AND, 4 = OR, 5 = XOR, 6 = four-lane 16-bit add, and 7 = add.
- R7: Opcode 6 adds each 16-bit lane on its own, modulo 2^16. No carry passes into the next lane.
- R8: With the pass-through bit set, the output after edge t+1 is A(t−dA) with A's valid bit. Operand B and the accumulate bit have no effect.
- R9: With the accumulate bit set (and pass-through clear), every valid aligned pair adds its result to the accumulator. acc_clr restarts the sum from zero in the same cycle, so the sum becomes 0 plus that cycle's result. Without acc_emit the output stays invalid.
- R10: In accumulate mode, acc_emit in cycle t presents the accumulator value updated at edge t+1 on the output after that edge, with out_valid set.
- R11: out_data is zero whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration enable; captures cfg_word |
| cfg_word | input | 15 | Configuration word (layout in R3) |
| in_data | input | 256 | Four neighbouring 64-bit switch outputs, port k at bits k*64 +: 64 |
| in_valid | input | 4 | Valid bit for each neighbouring port |
| acc_clr | input | 1 | Restart the reduction sum |
| acc_emit | input | 1 | Present the reduction sum on the output |
| out_data | output | 64 | Result |
| out_valid | output | 1 | Result valid |

## Verification
The assertions assume that the configuration does not change while the element is in RUN. The only way to change it is to raise cfg_en, which always passes through LOAD, and the stimulus reconfigures only through that route. The assertions also assume that acc_clr and acc_emit carry meaning only in accumulate mode, so the stimulus drives them only in the reduction phase. Operand data and valid patterns, on the other hand, range freely: they include sparse valids, lane-overflowing values, and reconfiguration while valid data is still in flight inside the delay lines.

// File: rtl/spe_pkg.sv
package spe_pkg;

    typedef enum logic [2:0] {
        OP_ADD      = 3'd0,
        OP_SUB      = 3'd1,
        OP_MUL      = 3'd2,
        OP_AND      = 3'd3,
        OP_OR       = 3'd4,
        OP_XOR      = 3'd5,
        OP_LANE_ADD = 3'd6,
        OP_SPARE    = 3'd7
    } spe_op_e;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } spe_state_e;

endpackage

// File: rtl/spe_cfg_ctrl.sv
module spe_cfg_ctrl
    import spe_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int DLY_W = 3,
    parameter int CFG_W = 5 + 2 * SEL_W + 2 * DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [CFG_W-1:0] cfg_word,
    output spe_state_e       state,
    output spe_op_e          op,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic [DLY_W-1:0] dly_a,
    output logic [DLY_W-1:0] dly_b,
    output logic             pass_mode,
    output logic             acc_mode
);
    localparam int SA_LSB   = 3;
    localparam int SB_LSB   = SA_LSB + SEL_W;
    localparam int DA_LSB   = SB_LSB + SEL_W;
    localparam int DB_LSB   = DA_LSB + DLY_W;
    localparam int PASS_BIT = DB_LSB + DLY_W;
    localparam int ACC_BIT  = PASS_BIT + 1;

    spe_state_e       state_q, state_d;
    logic [CFG_W-1:0] cfg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNCFG;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG: state_d = cfg_en ? ST_LOAD : ST_UNCFG;
            ST_LOAD:  state_d = cfg_en ? ST_LOAD : ST_RUN;
            ST_RUN:   state_d = cfg_en ? ST_LOAD : ST_RUN;
            default:  state_d = ST_UNCFG;
        endcase
    end

    // configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_en) cfg_q <= cfg_word;
    end

    // field outputs
    always_comb begin
        state     = state_q;
        op        = spe_op_e'(cfg_q[2:0]);
        sel_a     = cfg_q[SA_LSB +: SEL_W];
        sel_b     = cfg_q[SB_LSB +: SEL_W];
        dly_a     = cfg_q[DA_LSB +: DLY_W];
        dly_b     = cfg_q[DB_LSB +: DLY_W];
        pass_mode = cfg_q[PASS_BIT];
        acc_mode  = cfg_q[ACC_BIT];
    end

    AST_LOAD_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !cfg_en) |=> (state_q == ST_RUN)); // R2
    AST_ENABLE_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (state_q == ST_LOAD)); // R2
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cfg_en) |=> $stable(cfg_q)); // R3

endmodule

// File: rtl/spe_delay_line.sv
module spe_delay_line #(
    parameter int W        = 64,
    parameter int FIFO_LEN = 7,
    parameter int DLY_W    = $clog2(FIFO_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_vld,
    input  logic [W-1:0]     in_dat,
    input  logic [DLY_W-1:0] dly,
    output logic             out_vld,
    output logic [W-1:0]     out_dat
);
    logic [W-1:0]        stg_d [FIFO_LEN];
    logic [FIFO_LEN-1:0] stg_v;
    logic [DLY_W-1:0]    eff;

    for (genvar j = 0; j < FIFO_LEN; j++) begin : g_stage
        if (j == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_v[0] <= 1'b0;
                    stg_d[0] <= '0;
                end else begin
                    stg_v[0] <= in_vld & ~flush;
                    stg_d[0] <= in_dat;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_v[j] <= 1'b0;
                    stg_d[j] <= '0;
                end else begin
                    stg_v[j] <= stg_v[j-1] & ~flush;
                    stg_d[j] <= stg_d[j-1];
                end
            end
        end
    end

    // settings above FIFO_LEN saturate to the deepest tap
    always_comb begin
        eff = (int'(dly) > FIFO_LEN) ? DLY_W'(FIFO_LEN) : dly;
        if (eff == '0) begin
            out_vld = in_vld;
            out_dat = in_dat;
        end else begin
            out_vld = stg_v[int'(eff) - 1];
            out_dat = stg_d[int'(eff) - 1];
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (eff == '0 || !out_vld)); // R2

endmodule

// File: rtl/spe_alu.sv
module spe_alu
    import spe_pkg::*;
#(
    parameter int W      = 64,
    parameter int LANE_W = 16
) (
    input  spe_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int LANES = W / LANE_W;

    logic [W-1:0] lane_sum;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_sum[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W];
    end
    if (LANES * LANE_W < W) begin : g_rest
        assign lane_sum[W-1:LANES*LANE_W] = a[W-1:LANES*LANE_W] + b[W-1:LANES*LANE_W];
    end

    always_comb begin
        unique case (op)
            OP_ADD:      y = a + b;
            OP_SUB:      y = a - b;
            OP_MUL:      y = a * b;
            OP_AND:      y = a & b;
            OP_OR:       y = a | b;
            OP_XOR:      y = a ^ b;
            OP_LANE_ADD: y = lane_sum;
            OP_SPARE:    y = a + b;
            default:     y = a + b;
        endcase
    end

endmodule

// File: rtl/spatial_pe.sv
module spatial_pe
    import spe_pkg::*;
#(
    parameter  int DATA_W   = 64,
    parameter  int NPORT    = 4,
    parameter  int FIFO_LEN = 7,
    parameter  int LANE_W   = 16,
    localparam int SEL_W    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int DLY_W    = $clog2(FIFO_LEN + 1),
    localparam int CFG_W    = 5 + 2 * SEL_W + 2 * DLY_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_en,
    input  logic [CFG_W-1:0]        cfg_word,
    input  logic [NPORT*DATA_W-1:0] in_data,
    input  logic [NPORT-1:0]        in_valid,
    input  logic                    acc_clr,
    input  logic                    acc_emit,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_valid
);
    spe_state_e       state;
    spe_op_e          op;
    logic [SEL_W-1:0] sel_a, sel_b;
    logic [DLY_W-1:0] dly_a, dly_b;
    logic             pass_mode, acc_mode, run;

    logic [SEL_W-1:0]  sel_v [2];
    logic [DLY_W-1:0]  dly_v [2];
    logic [DATA_W-1:0] raw_d [2];
    logic              raw_v [2];
    logic [DATA_W-1:0] opd_d [2];
    logic              dl_v  [2];
    logic              opd_v [2];
    logic [DATA_W-1:0] a_d, b_d, alu_y, acc_q, acc_n, nd;
    logic              nv;

    spe_cfg_ctrl #(.SEL_W(SEL_W), .DLY_W(DLY_W), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
        .state(state), .op(op), .sel_a(sel_a), .sel_b(sel_b),
        .dly_a(dly_a), .dly_b(dly_b), .pass_mode(pass_mode), .acc_mode(acc_mode)
    );

    assign run      = (state == ST_RUN);
    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;
    assign dly_v[0] = dly_a;
    assign dly_v[1] = dly_b;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        assign raw_d[k] = in_data[int'(sel_v[k]) * DATA_W +: DATA_W];
        assign raw_v[k] = in_valid[sel_v[k]];

        spe_delay_line #(.W(DATA_W), .FIFO_LEN(FIFO_LEN), .DLY_W(DLY_W)) u_dly (
            .clk(clk), .rst_n(rst_n), .flush(~run),
            .in_vld(raw_v[k]), .in_dat(raw_d[k]), .dly(dly_v[k]),
            .out_vld(dl_v[k]), .out_dat(opd_d[k])
        );

        assign opd_v[k] = run & dl_v[k];
    end

    assign a_d = opd_d[0];
    assign b_d = opd_d[1];

    spe_alu #(.W(DATA_W), .LANE_W(LANE_W)) u_alu (
        .op(op), .a(a_d), .b(b_d), .y(alu_y)
    );

    // output selection per mode
    always_comb begin
        acc_n = acc_q;
        nv    = 1'b0;
        nd    = '0;
        if (!run) begin
            acc_n = '0;
        end else if (pass_mode) begin
            nv = opd_v[0];
            nd = opd_v[0] ? a_d : '0;
        end else if (acc_mode) begin
            acc_n = (acc_clr ? '0 : acc_q) + ((opd_v[0] && opd_v[1]) ? alu_y : '0);
            nv    = acc_emit;
            nd    = acc_emit ? acc_n : '0;
        end else begin
            nv = opd_v[0] & opd_v[1];
            nd = nv ? alu_y : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            acc_q     <= '0;
        end else begin
            out_valid <= nv;
            out_data  <= nd;
            acc_q     <= acc_n;
        end
    end

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out_valid); // R2
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0)); // R11
    AST_PASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pass_mode && opd_v[0]) |=> (out_valid && out_data == $past(a_d))); // R8
    AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pass_mode && acc_mode && !acc_emit) |=> !out_valid); // R9

endmodule

// File: tb/spatial_pe_tb_top.sv
`timescale 1ns/1ps
module spatial_pe_tb_top;
    localparam int W  = 64;
    localparam int NP = 4;
    localparam int CW = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_en;
    logic [CW-1:0] cfg_word;
    logic [NP*W-1:0] in_data;
    logic [NP-1:0] in_valid;
    logic          acc_clr, acc_emit;
    logic [W-1:0]  out_data;
    logic          out_valid;

    always #4 clk = ~clk;

    spatial_pe dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
        .in_data(in_data), .in_valid(in_valid), .acc_clr(acc_clr),
        .acc_emit(acc_emit), .out_data(out_data), .out_valid(out_valid)
    );

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    chk_on = 1'b0;
    bit    done = 1'b0;

    // ---------------- reference model ----------------
    typedef struct { logic [NP-1:0] v; logic [NP*W-1:0] d; } rec_t;
    rec_t hist[$];
    int          m_st;      // 0 unconfigured, 1 loading, 2 running
    logic [CW-1:0] m_cfg;
    logic [W-1:0]  m_acc;
    int          run_cnt;
    logic        exp_v;
    logic [W-1:0] exp_d;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    function automatic logic [W-1:0] ref_op(int op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r;
        case (op)
            1: r = a - b;
            2: r = a * b;
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: for (int l = 0; l < 4; l++) r[l*16 +: 16] = a[l*16 +: 16] + b[l*16 +: 16];
            default: r = a + b;
        endcase
        return r;
    endfunction

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            m_st = 0; m_cfg = '0; m_acc = '0; run_cnt = 0;
            exp_v = 1'b0; exp_d = '0;
        end else begin : model
            rec_t r;
            bit run, av, bv, ps, ac;
            int op, sa, sb, da, db;
            logic [W-1:0] ad, bd, res, nacc;
            run = (m_st == 2);
            r.v = in_valid; r.d = in_data;
            hist.push_front(r);
            if (hist.size() > 20) void'(hist.pop_back());
            run_cnt = run ? run_cnt + 1 : 0;
            op = int'(m_cfg[2:0]); sa = int'(m_cfg[4:3]); sb = int'(m_cfg[6:5]);
            da = int'(m_cfg[9:7]); db = int'(m_cfg[12:10]);
            ps = m_cfg[13]; ac = m_cfg[14];
            av = run && (run_cnt > da) && hist[da].v[sa];
            bv = run && (run_cnt > db) && hist[db].v[sb];
            ad = hist[da].d[sa*W +: W];
            bd = hist[db].d[sb*W +: W];
            res = ref_op(op, ad, bd);
            exp_v = 1'b0; exp_d = '0;
            if (!run) begin
                m_acc = '0;
            end else if (ps) begin
                exp_v = av; exp_d = av ? ad : '0;
            end else if (ac) begin
                nacc = (acc_clr ? '0 : m_acc) + ((av && bv) ? res : '0);
                m_acc = nacc;
                exp_v = acc_emit; exp_d = acc_emit ? nacc : '0;
            end else begin
                exp_v = av && bv; exp_d = exp_v ? res : '0;
            end
            if (cfg_en) m_cfg = cfg_word;
            case (m_st)
                0: m_st = cfg_en ? 1 : 0;
                1: m_st = cfg_en ? 1 : 2;
                default: m_st = cfg_en ? 1 : 2;
            endcase
        end
    end

    // every clock: compare outputs with the model (R11 covered by exp_d = 0 when invalid)
    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (out_valid !== exp_v || out_data !== exp_d) begin
                failures++;
                $display("FAIL %s actual valid=%0b data=%h expected valid=%0b data=%h",
                         tag, out_valid, out_data, exp_v, exp_d);
            end
        end
    end

    // ---------------- stimulus ----------------
    // R3: word = {acc, pass, dlyB[2:0], dlyA[2:0], selB[1:0], selA[1:0], op[2:0]}
    task automatic load_cfg(int op, int sa, int sb, int da, int db, bit ps, bit ac, int hold);
        @(negedge clk);
        cfg_en   = 1'b1;
        cfg_word = {ac, ps, 3'(db), 3'(da), 2'(sb), 2'(sa), 3'(op)};
        repeat (hold - 1) @(negedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    // vmode 0: all valid, 1: random valids, 2: lane-edge values
    task automatic drive(int n, int vmode, bit acc_ctl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                logic [63:0] x;
                x = rnd();
                if (vmode == 2) x = (x[0] ? 64'hFFFF_0001_8000_7FFF : 64'h0001_FFFF_8000_0001) ^ {48'h0, x[8:1], 8'h0};
                in_data[p*W +: W] = x;
            end
            in_valid = (vmode == 1) ? 4'(rnd()) : 4'hF;
            if (acc_ctl) begin
                acc_clr  = (rnd() % 13) == 0;
                acc_emit = (rnd() % 3) == 0;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; cfg_en = 1'b0; cfg_word = '0;
        in_data = '0; in_valid = '0; acc_clr = 1'b0; acc_emit = 1'b0;
        repeat (3) @(negedge clk);
        tag = "R1";
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            failures++;
            $display("FAIL R1 reset actual valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
        end
        chk_on = 1'b1;
        rst_n = 1'b1;
        drive(10, 0, 1'b0);          // R1: unconfigured, valid inputs give no output

        tag = "R4 R6 add";
        load_cfg(0, 2, 1, 0, 0, 1'b0, 1'b0, 1);
        drive(30, 0, 1'b0);

        tag = "R5 sub skew";
        load_cfg(1, 0, 3, 2, 5, 1'b0, 1'b0, 1);
        drive(40, 0, 1'b0);
        drive(40, 1, 1'b0);

        for (int op = 2; op <= 7; op++) begin
            tag = (op == 6) ? "R7 lanes" : "R6 ops";
            load_cfg(op, op % 4, (op + 1) % 4, op % 3, 7 - op % 3, 1'b0, 1'b0, 1);
            drive(30, (op == 6) ? 2 : 1, 1'b0);
        end

        tag = "R5 depth";
        load_cfg(0, 3, 3, 7, 0, 1'b0, 1'b0, 1);
        drive(40, 1, 1'b0);

        tag = "R8 pass";
        load_cfg(2, 1, 0, 0, 0, 1'b1, 1'b1, 1);
        drive(30, 1, 1'b0);
        load_cfg(0, 3, 2, 4, 1, 1'b1, 1'b0, 1);
        drive(30, 1, 1'b0);

        tag = "R9 R10 accumulate";
        load_cfg(0, 0, 1, 1, 0, 1'b0, 1'b1, 1);
        drive(80, 1, 1'b1);
        load_cfg(5, 2, 3, 0, 3, 1'b0, 1'b1, 1);
        drive(80, 0, 1'b1);
        acc_clr = 1'b0; acc_emit = 1'b0;

        tag = "R2 reconfig";
        load_cfg(1, 1, 2, 6, 2, 1'b0, 1'b0, 1);
        drive(12, 0, 1'b0);
        load_cfg(4, 0, 0, 3, 3, 1'b0, 1'b0, 4);  // long LOAD while data held valid
        drive(20, 0, 1'b0);

        tag = "R11 idle";
        drive(5, 1, 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule